// File: doc/BRIEF.md
# Feature Configuration Word Controller

This block holds a 16-bit word of feature settings for a dual-interface tag front end. The word carries the serial-bus address bits, the serial-port enable, one enable per antenna port, the clock-line interrupt enable, three read-protect flags and an alarm flag. Its low four bits are live status indicators that come from outside logic.

Three update paths reach the word. A plain write from the wireless side and a plain write from the serial bus each replace only the bits that side may change. A toggle command inverts selected bits. For a toggle, the bits to invert are recovered by XOR of the command payload with the session handle, and the command only acts in the open or secured protocol state. Every accepted update must leave at least one antenna port enabled. An update that would switch both ports off is refused as a whole.

Every accepted update that alters the word raises a one-cycle commit strobe, so a nonvolatile store can take the new value. The decoded fields drive the surrounding interface logic directly.

Top module: `cfgword_ctrl`

## Requirements
- R1: Bit layout of the word: 0 download indicator, 1 external supply, 2 RF active, 3 upload indicator, 4/5/6 address bits 3/2/1, 7 serial-port enable, 8 antenna 1 enable, 9 antenna 2 enable, 10 reserved (always 0), 11 interrupt enable, 12 user read-protect, 13 EPC read-protect, 14 TID serial read-protect, 15 alarm. `i2cAddr` is {bit4, bit5, bit6}, and each single-bit output mirrors its bit. After reset the word equals the default vector masked to bits 4–9 and 11–15 (default 16'h03C0, address 3'b001).
- R2: Bits 3:0 show `{ulInd, rfActive, extSupply, dlInd}` as sampled at the previous clock edge. They read 0 while reset is held, and no write or toggle changes them.
- R3: A wireless write (`rfWrEn`) loads bits 4–9 and 11–15 from `rfWrData`. All other bits keep their value.
- R4: A serial write (`i2cWrEn`) loads only bits 8, 9, 12, 13 and 14 from `i2cWrData`. All other bits keep their value.
- R5: A toggle inverts every bit among 4–9 and 11–15 that is set in `tglData ^ tglHandle`. Other set bits of the mask have no effect.
- R6: Issuing the same toggle twice restores the original word.
- R7: A toggle acts only when `protoState` is 4 (open) or 5 (secured). In any other state (0 ready, 1 arbitrate, 2 reply, 3 acknowledged, 6 killed) it changes nothing and gives no reply.
- R8: For a toggle in a permitted state, `tglReplyValid` is high for one cycle, one cycle after the request. In that cycle `cfgWord` holds the resulting word, or the unchanged word if the toggle was refused.
- R9: In the dual-port variant, any update whose result would clear both bits 8 and 9 is refused entirely, and the previous word is kept.
- R10: In the single-port variant (`DUAL_PORT=0`), bit 8 is fixed at 1 and bit 9 is fixed at 0. No write or toggle changes either of them.
- R11: Only one update is taken per cycle, in the priority order: permitted toggle, then wireless write, then serial write. A lower request in the same cycle is dropped, even when the higher one is refused.
- R12: `commitStrobe` is high for exactly the one cycle after an accepted update that changed the stored bits, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rfWrEn | input | 1 | Wireless-side write request |
| rfWrData | input | 16 | Wireless-side write data |
| i2cWrEn | input | 1 | Serial-bus write request |
| i2cWrData | input | 16 | Serial-bus write data |
| tglEn | input | 1 | Toggle command request |
| tglData | input | 16 | Toggle payload, masked with the handle |
| tglHandle | input | 16 | Session handle |
| protoState | input | 3 | Protocol state code (4 open, 5 secured) |
| dlInd | input | 1 | Download indicator status |
| extSupply | input | 1 | External supply present |
| rfActive | input | 1 | RF activity status |
| ulInd | input | 1 | Upload indicator status |
| cfgWord | output | 16 | Full word, status included |
| tglReplyValid | output | 1 | Toggle reply strobe; the reply value is `cfgWord` |
| commitStrobe | output | 1 | Store the new persistent word |
| i2cAddr | output | 3 | Serial address bits 3..1 |
| i2cEnable | output | 1 | Serial port enabled |
| ant1En | output | 1 | Antenna port 1 enabled |
| ant2En | output | 1 | Antenna port 2 enabled |
| intEnable | output | 1 | Clock-line interrupt enabled |
| rdProtUser | output | 1 | User memory read-protected |
| rdProtEpc | output | 1 | EPC memory read-protected |
| rdProtTid | output | 1 | TID serial read-protected |
| alarm | output | 1 | Alarm flag |

## Verification
A permitted toggle and a plain write can arrive in the same cycle; the same holds for a wireless write and a serial write. The bench drives these pairs together on one falling edge. It checks that only the winner's change appears one cycle later, and that the commit strobe matches that change alone. It also pairs a toggle that is refused by the antenna rule with a serial write, and expects the word to stay unchanged and no commit. A second instance built as the single-port variant receives the same stimulus and is checked for its fixed antenna bits.

// File: rtl/cfgword_pkg.sv
package cfgword_pkg;
  localparam int WORD_W  = 16;
  localparam int STATE_W = 3;

  // bit positions of the word
  localparam int B_DLIND  = 0;
  localparam int B_EXTSUP = 1;
  localparam int B_RFACT  = 2;
  localparam int B_ULIND  = 3;
  localparam int B_ADR3   = 4;
  localparam int B_ADR2   = 5;
  localparam int B_ADR1   = 6;
  localparam int B_I2CEN  = 7;
  localparam int B_ANT1   = 8;
  localparam int B_ANT2   = 9;
  localparam int B_RSVD   = 10;
  localparam int B_INTEN  = 11;
  localparam int B_RPUSER = 12;
  localparam int B_RPEPC  = 13;
  localparam int B_RPTID  = 14;
  localparam int B_ALARM  = 15;

  localparam logic [STATE_W-1:0] ST_OPEN    = 3'd4;
  localparam logic [STATE_W-1:0] ST_SECURED = 3'd5;

  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  localparam logic [WORD_W-1:0] STATUS_MASK =
    (ONE << B_DLIND) | (ONE << B_EXTSUP) | (ONE << B_RFACT) | (ONE << B_ULIND);
  localparam logic [WORD_W-1:0] PERS_MASK = ~(STATUS_MASK | (ONE << B_RSVD));
  localparam logic [WORD_W-1:0] ANT_MASK  = (ONE << B_ANT1) | (ONE << B_ANT2);
  localparam logic [WORD_W-1:0] PROT_MASK =
    (ONE << B_RPUSER) | (ONE << B_RPEPC) | (ONE << B_RPTID);

  typedef enum logic [1:0] {SRC_NONE, SRC_I2C, SRC_RF, SRC_TGL} srcSel_e;

  typedef struct packed {
    srcSel_e src;
    logic    load;
  } cfgStrobe_t;
endpackage

// File: rtl/cfgword_ctl.sv
module cfgword_ctl
  import cfgword_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               rfWrEn,
  input  logic               i2cWrEn,
  input  logic               tglEn,
  input  logic [STATE_W-1:0] protoState,
  input  logic               rejTgl,
  input  logic               rejRf,
  input  logic               rejI2c,
  output cfgStrobe_t         strobe,
  output logic               replyValid
);
  logic tglOk;
  assign tglOk = tglEn && ((protoState == ST_OPEN) || (protoState == ST_SECURED));

  always_comb begin
    strobe.src  = SRC_NONE;
    strobe.load = 1'b0;
    if (tglOk) begin
      strobe.src  = SRC_TGL;
      strobe.load = !rejTgl;
    end else if (rfWrEn) begin
      strobe.src  = SRC_RF;
      strobe.load = !rejRf;
    end else if (i2cWrEn) begin
      strobe.src  = SRC_I2C;
      strobe.load = !rejI2c;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) replyValid <= 1'b0;
    else       replyValid <= tglOk;
  end

  // R7: a reply only ever follows a request made in open or secured state
  p_reply_state_r7: assert property (@(posedge clk) disable iff (!rstN)
    replyValid |-> ($past(tglEn) &&
      (($past(protoState) == ST_OPEN) || ($past(protoState) == ST_SECURED))));

  // R11: a toggle request in a permitted state always shuts out the writes
  p_tgl_first_r11: assert property (@(posedge clk) disable iff (!rstN)
    (replyValid && $past(rfWrEn || i2cWrEn)) |-> $past(strobe.src == SRC_TGL));
endmodule

// File: rtl/cfgword_dp.sv
module cfgword_dp
  import cfgword_pkg::*;
#(
  parameter bit                DUAL_PORT    = 1'b1,
  parameter logic [WORD_W-1:0] DEFAULT_WORD = 16'h03C0
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [WORD_W-1:0] rfWrData,
  input  logic [WORD_W-1:0] i2cWrData,
  input  logic [WORD_W-1:0] tglData,
  input  logic [WORD_W-1:0] tglHandle,
  input  logic              dlInd,
  input  logic              extSupply,
  input  logic              rfActive,
  input  logic              ulInd,
  output logic              rejTgl,
  output logic              rejRf,
  output logic              rejI2c,
  output logic [WORD_W-1:0] cfgWord,
  output logic              commitStrobe
);
  // per-variant access masks and reset value
  localparam logic [WORD_W-1:0] FIX_ONE  = DUAL_PORT ? '0 : (ONE << B_ANT1);
  localparam logic [WORD_W-1:0] FIX_ZERO = DUAL_PORT ? '0 : (ONE << B_ANT2);
  localparam logic [WORD_W-1:0] RF_MASK  = DUAL_PORT ? PERS_MASK : (PERS_MASK & ~ANT_MASK);
  localparam logic [WORD_W-1:0] I2C_MASK = DUAL_PORT ? (PROT_MASK | ANT_MASK) : PROT_MASK;
  localparam logic [WORD_W-1:0] RESET_PERS =
    (DEFAULT_WORD & PERS_MASK & ~FIX_ZERO) | FIX_ONE;

  logic [WORD_W-1:0] persQ;
  logic [3:0]        statusQ;
  logic [WORD_W-1:0] candTgl, candRf, candI2c, nextPers;
  logic              changed;

  function automatic logic antsOff(input logic [WORD_W-1:0] w);
    return DUAL_PORT && !(w[B_ANT1] || w[B_ANT2]);
  endfunction

  always_comb begin
    candTgl = persQ ^ ((tglData ^ tglHandle) & RF_MASK);
    candRf  = (persQ & ~RF_MASK)  | (rfWrData  & RF_MASK);
    candI2c = (persQ & ~I2C_MASK) | (i2cWrData & I2C_MASK);
  end

  assign rejTgl = antsOff(candTgl);
  assign rejRf  = antsOff(candRf);
  assign rejI2c = antsOff(candI2c);

  always_comb begin
    case (strobe.src)
      SRC_TGL: nextPers = candTgl;
      SRC_RF:  nextPers = candRf;
      SRC_I2C: nextPers = candI2c;
      default: nextPers = persQ;
    endcase
  end

  assign changed = (nextPers != persQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      persQ        <= RESET_PERS;
      statusQ      <= '0;
      commitStrobe <= 1'b0;
    end else begin
      if (strobe.load) persQ <= nextPers;
      commitStrobe <= strobe.load && changed;
      statusQ      <= {ulInd, rfActive, extSupply, dlInd};
    end
  end

  always_comb begin
    cfgWord          = persQ;
    cfgWord[B_DLIND]  = statusQ[0];
    cfgWord[B_EXTSUP] = statusQ[1];
    cfgWord[B_RFACT]  = statusQ[2];
    cfgWord[B_ULIND]  = statusQ[3];
  end

  // R12: a commit only follows a real change of the stored bits
  p_commit_change_r12: assert property (@(posedge clk) disable iff (!rstN)
    commitStrobe |-> (persQ != $past(persQ)));

  // R4: a serial write never reaches the bits it may not change
  p_i2c_ro_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.src == SRC_I2C) |-> (((persQ ^ $past(persQ)) & ~I2C_MASK) == '0));

  // R3: a wireless write never reaches bits outside its mask
  p_rf_ro_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.src == SRC_RF) |-> (((persQ ^ $past(persQ)) & ~RF_MASK) == '0));

  // R11: with no request selected the stored word holds
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.src == SRC_NONE) |-> $stable(persQ));

  generate
    if (DUAL_PORT) begin : g_dual
      // R9: one antenna port is always left enabled
      p_ant_alive_r9: assert property (@(posedge clk) disable iff (!rstN)
        persQ[B_ANT1] || persQ[B_ANT2]);
    end else begin : g_single
      // R10: fixed antenna bits in the single-port variant
      p_ant_fixed_r10: assert property (@(posedge clk) disable iff (!rstN)
        persQ[B_ANT1] && !persQ[B_ANT2]);
    end
  endgenerate
endmodule

// File: rtl/cfgword_ctrl.sv
module cfgword_ctrl
  import cfgword_pkg::*;
#(
  parameter bit                DUAL_PORT    = 1'b1,
  parameter logic [WORD_W-1:0] DEFAULT_WORD = 16'h03C0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rfWrEn,
  input  logic [WORD_W-1:0]  rfWrData,
  input  logic               i2cWrEn,
  input  logic [WORD_W-1:0]  i2cWrData,
  input  logic               tglEn,
  input  logic [WORD_W-1:0]  tglData,
  input  logic [WORD_W-1:0]  tglHandle,
  input  logic [STATE_W-1:0] protoState,
  input  logic               dlInd,
  input  logic               extSupply,
  input  logic               rfActive,
  input  logic               ulInd,
  output logic [WORD_W-1:0]  cfgWord,
  output logic               tglReplyValid,
  output logic               commitStrobe,
  output logic [2:0]         i2cAddr,
  output logic               i2cEnable,
  output logic               ant1En,
  output logic               ant2En,
  output logic               intEnable,
  output logic               rdProtUser,
  output logic               rdProtEpc,
  output logic               rdProtTid,
  output logic               alarm
);
  cfgStrobe_t strobe;
  logic       rejTgl, rejRf, rejI2c;

  cfgword_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .rfWrEn     (rfWrEn),
    .i2cWrEn    (i2cWrEn),
    .tglEn      (tglEn),
    .protoState (protoState),
    .rejTgl     (rejTgl),
    .rejRf      (rejRf),
    .rejI2c     (rejI2c),
    .strobe     (strobe),
    .replyValid (tglReplyValid)
  );

  cfgword_dp #(
    .DUAL_PORT    (DUAL_PORT),
    .DEFAULT_WORD (DEFAULT_WORD)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .rfWrData     (rfWrData),
    .i2cWrData    (i2cWrData),
    .tglData      (tglData),
    .tglHandle    (tglHandle),
    .dlInd        (dlInd),
    .extSupply    (extSupply),
    .rfActive     (rfActive),
    .ulInd        (ulInd),
    .rejTgl       (rejTgl),
    .rejRf        (rejRf),
    .rejI2c       (rejI2c),
    .cfgWord      (cfgWord),
    .commitStrobe (commitStrobe)
  );

  assign i2cAddr    = {cfgWord[B_ADR3], cfgWord[B_ADR2], cfgWord[B_ADR1]};
  assign i2cEnable  = cfgWord[B_I2CEN];
  assign ant1En     = cfgWord[B_ANT1];
  assign ant2En     = cfgWord[B_ANT2];
  assign intEnable  = cfgWord[B_INTEN];
  assign rdProtUser = cfgWord[B_RPUSER];
  assign rdProtEpc  = cfgWord[B_RPEPC];
  assign rdProtTid  = cfgWord[B_RPTID];
  assign alarm      = cfgWord[B_ALARM];
endmodule

// File: tb/tb_cfgword_ctrl.sv
`timescale 1ns/1ps
module tb_cfgword_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rfWrEn = 1'b0, i2cWrEn = 1'b0, tglEn = 1'b0;
  logic [15:0] rfWrData = '0, i2cWrData = '0, tglData = '0, tglHandle = '0;
  logic [2:0]  protoState = '0;
  logic        dlInd = 1'b0, extSupply = 1'b0, rfActive = 1'b0, ulInd = 1'b0;

  logic [15:0] cfgWord, cfgWordS;
  logic        tglReplyValid, commitStrobe, rvS, cmS;
  logic [2:0]  i2cAddr, i2cAddrS;
  logic        i2cEnable, ant1En, ant2En, intEnable, rdProtUser, rdProtEpc, rdProtTid, alarm;
  logic        i2cEnS, ant1S, ant2S, intS, rpuS, rpeS, rptS, alS;

  int checks = 0;
  int fails  = 0;

  localparam logic [15:0] HANDLE = 16'hA5C3;
  localparam logic [15:0] RFM    = 16'hFBF0;  // R3 bits 4-9, 11-15
  localparam logic [15:0] I2M    = 16'h7300;  // R4 bits 8, 9, 12-14

  always #5 clk = ~clk;

  cfgword_ctrl dut (
    .clk(clk), .rstN(rstN), .rfWrEn(rfWrEn), .rfWrData(rfWrData),
    .i2cWrEn(i2cWrEn), .i2cWrData(i2cWrData), .tglEn(tglEn), .tglData(tglData),
    .tglHandle(tglHandle), .protoState(protoState), .dlInd(dlInd),
    .extSupply(extSupply), .rfActive(rfActive), .ulInd(ulInd),
    .cfgWord(cfgWord), .tglReplyValid(tglReplyValid), .commitStrobe(commitStrobe),
    .i2cAddr(i2cAddr), .i2cEnable(i2cEnable), .ant1En(ant1En), .ant2En(ant2En),
    .intEnable(intEnable), .rdProtUser(rdProtUser), .rdProtEpc(rdProtEpc),
    .rdProtTid(rdProtTid), .alarm(alarm)
  );

  cfgword_ctrl #(.DUAL_PORT(1'b0)) dutSingle (
    .clk(clk), .rstN(rstN), .rfWrEn(rfWrEn), .rfWrData(rfWrData),
    .i2cWrEn(i2cWrEn), .i2cWrData(i2cWrData), .tglEn(tglEn), .tglData(tglData),
    .tglHandle(tglHandle), .protoState(protoState), .dlInd(dlInd),
    .extSupply(extSupply), .rfActive(rfActive), .ulInd(ulInd),
    .cfgWord(cfgWordS), .tglReplyValid(rvS), .commitStrobe(cmS),
    .i2cAddr(i2cAddrS), .i2cEnable(i2cEnS), .ant1En(ant1S), .ant2En(ant2S),
    .intEnable(intS), .rdProtUser(rpuS), .rdProtEpc(rpeS),
    .rdProtTid(rptS), .alarm(alS)
  );

  typedef struct {
    logic [15:0] word;
    logic        commit;
    logic        rv;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  logic [15:0] mPers = 16'h03C0;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // driver: drive one cycle at a falling edge and push the expected outcome
  task automatic cyc(input logic rE, input logic [15:0] rD,
                     input logic iE, input logic [15:0] iD,
                     input logic tE, input logic [15:0] mask, input logic [2:0] st,
                     input logic [3:0] stat, input string tag);
    exp_t        e;
    logic        tOk, sel, acc;
    logic [15:0] cand;
    rfWrEn = rE; rfWrData = rD; i2cWrEn = iE; i2cWrData = iD;
    tglEn = tE; tglHandle = HANDLE; tglData = mask ^ HANDLE; protoState = st;
    {ulInd, rfActive, extSupply, dlInd} = stat;
    tOk  = tE && (st == 3'd4 || st == 3'd5);          // R7
    sel  = 1'b1;
    cand = mPers;
    if (tOk)      cand = mPers ^ (mask & RFM);        // R5, R11
    else if (rE)  cand = (mPers & ~RFM) | (rD & RFM); // R3
    else if (iE)  cand = (mPers & ~I2M) | (iD & I2M); // R4
    else          sel = 1'b0;
    acc = sel && (cand[9] || cand[8]);                 // R9
    e.commit = acc && (cand != mPers);                 // R12
    if (acc) mPers = cand;
    e.word = mPers | {12'b0, stat};                    // R2
    e.rv   = tOk;                                      // R8
    e.tag  = tag;
    sbq.push_back(e);
    @(negedge clk);
  endtask

  // monitor: one expected item per clock, sampled just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        check({e.tag, " word"}, {16'b0, cfgWord}, {16'b0, e.word});
        check({e.tag, " R12 commit"}, {31'b0, commitStrobe}, {31'b0, e.commit});
        check({e.tag, " R8 reply"}, {31'b0, tglReplyValid}, {31'b0, e.rv});
        check({e.tag, " R1 decode"},
              {20'b0, i2cAddr, i2cEnable, ant1En, ant2En, intEnable,
               rdProtUser, rdProtEpc, rdProtTid, alarm},
              {20'b0, e.word[4], e.word[5], e.word[6], e.word[7], e.word[8], e.word[9],
               e.word[11], e.word[12], e.word[13], e.word[14], e.word[15]});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    {ulInd, rfActive, extSupply, dlInd} = 4'hF;
    repeat (3) @(negedge clk);
    // R1 / R2 reset state, indicators stay 0 under reset
    check("R1 reset word", {16'b0, cfgWord}, {16'b0, 16'h03C0});
    check("R1 reset addr", {29'b0, i2cAddr}, {29'b0, 3'b001});
    check("R2 reset indicators", {28'b0, cfgWord[3:0]}, 32'd0);
    check("R12 reset commit", {31'b0, commitStrobe}, 32'd0);
    check("R10 single reset ant", {30'b0, ant1S, ant2S}, {30'b0, 2'b10});
    check("R10 single reset word", {16'b0, cfgWordS}, {16'b0, 16'h01C0});
    rstN = 1'b1;

    cyc(0, '0, 0, '0, 0, '0, 3'd0, 4'b1010, "R2 status");
    cyc(0, '0, 0, '0, 0, '0, 3'd0, 4'b0101, "R2 status");
    cyc(1, 16'hFFFF, 0, '0, 0, '0, 3'd0, 4'b0000, "R3 rf write all");
    cyc(0, '0, 1, 16'h0000, 0, '0, 3'd0, 4'b0000, "R9 i2c clears ants");
    cyc(0, '0, 1, 16'h0100, 0, '0, 3'd0, 4'b0000, "R4 i2c write");
    cyc(0, '0, 1, 16'hFFFF, 0, '0, 3'd0, 4'b0001, "R4 i2c write all");
    cyc(0, '0, 0, '0, 1, 16'h9000, 3'd4, 4'b0000, "R5 toggle open");
    cyc(0, '0, 0, '0, 1, 16'h9000, 3'd5, 4'b0000, "R6 toggle again");
    cyc(0, '0, 0, '0, 1, 16'hFFFF, 3'd3, 4'b0000, "R7 toggle acked");
    cyc(0, '0, 0, '0, 1, 16'hFFFF, 3'd6, 4'b0000, "R7 toggle killed");
    cyc(0, '0, 0, '0, 1, 16'hFFFF, 3'd0, 4'b0000, "R7 toggle ready");
    cyc(0, '0, 0, '0, 1, 16'h040F, 3'd4, 4'b1000, "R5 toggle masked bits");
    cyc(0, '0, 0, '0, 1, 16'h0300, 3'd4, 4'b0000, "R9 toggle both ants");
    cyc(0, '0, 0, '0, 1, 16'h0100, 3'd5, 4'b0000, "R8 toggle ant1");
    cyc(1, 16'h0000, 0, '0, 0, '0, 3'd0, 4'b0000, "R9 rf clears ants");
    // single-port instance took the same wireless write of zero
    check("R10 single after rf zero", {16'b0, cfgWordS}, {16'b0, 16'h0100});
    cyc(1, 16'hFFFF, 1, 16'h0000, 1, 16'h1000, 3'd4, 4'b0000, "R11 toggle beats writes");
    cyc(1, 16'h0300, 1, 16'h7300, 0, '0, 3'd0, 4'b0000, "R11 rf beats i2c");
    cyc(0, '0, 1, 16'h7000, 1, 16'h0300, 3'd5, 4'b0000, "R11 refused toggle blocks i2c");
    cyc(1, 16'h0300, 0, '0, 0, '0, 3'd0, 4'b0000, "R12 same value write");
    cyc(0, '0, 1, 16'h1200, 1, 16'hFFFF, 3'd2, 4'b0110, "R11 i2c with blocked toggle");
    cyc(0, '0, 0, '0, 0, '0, 3'd0, 4'b0000, "R12 idle");
    check("R10 single ant fixed", {30'b0, ant1S, ant2S}, {30'b0, 2'b10});
    cyc(0, '0, 0, '0, 1, 16'h0070, 3'd4, 4'b0000, "R1 toggle address");
    cyc(0, '0, 0, '0, 0, '0, 3'd0, 4'b0000, "R12 idle");

    @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule